// File: doc/BRIEF.md
# Clock Divider and Gating Tree

This block takes one fast root clock and derives four fixed-ratio clocks from it: a packet-processing clock at one third of the root rate, a double-rate core clock at one half, a core clock at one quarter and a fractional clock at two fifths. A fifth clock, the storage clock, is either the core clock or the two-fifths clock. A select bit in a small register chooses between them. The change-over runs through a glitch-free handshake, and the storage clock stays low while the sources hand over.

Up to 32 gated peripheral clocks hang off these sources. Each gated output has one fixed parent and one enable bit in a gating register. The enable is retimed on the falling edge of that parent, so turning a gate on or off only ever adds or removes whole high phases. A plain register port writes and reads the gating register and the storage select register. The port runs on the root clock. Read data is combinational from the address.

Top module: `clkdiv_gate_tree`

## Requirements
- R1: After reset the gating register and the storage select read back as zero, and every gated output stays low.
- R2: `clk_pkt` has exactly one third of the root frequency. Each high phase lasts 1.5 root periods.
- R3: `clk_x2` has half the root frequency and `clk_core` a quarter. Every edge of `clk_core` coincides with an edge of `clk_x2`.
- R4: `clk_sd` has two fifths of the root frequency: two full periods in every five root periods. Each high phase lasts 1.5 root periods.
- R5: Offset 0x700 holds the storage select in bit 0, and other bits read as zero. With bit 0 = 1, `clk_stor` runs at two fifths of the root rate; with bit 0 = 0 it follows `clk_core`.
- R6: A storage select change never produces a high pulse on `clk_stor` shorter than 1.5 root periods. The two sources are never enabled at the same time.
- R7: Offset 0x220 is the gating register. Bit i = 1 runs `gclk[i]`, bit i = 0 holds it low, and a read returns the stored enables.
- R8: Gating bits 10, 19 and 20 are unused. They read back as zero whatever is written, and their outputs never toggle.
- R9: Parents are fixed per gate. Gate 2 runs from the storage clock, gate 4 from the two-fifths clock, and gates 3, 5 and 9 from the packet clock. Gates 13, 14, 17, 25 and 26 run from the double-rate core clock, and every other used gate from the core clock.
- R10: A gate's enable changes only while its parent is low. Every high pulse on `gclk[i]` is as long as a full high phase of its parent.
- R11: Writes to any other offset change nothing, and reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_root | input | 1 | Fast root clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| clk_pkt | output | 1 | Root / 3 |
| clk_x2 | output | 1 | Root / 2 |
| clk_core | output | 1 | Root / 4 |
| clk_sd | output | 1 | Root × 2/5 |
| clk_stor | output | 1 | Selected storage clock |
| gclk | output | 32 | Gated peripheral clocks |

## Verification
Gate 2 runs from the storage clock, so a change of the storage select and a change of the gate-2 enable can fall in the same parent period. The enable retiming and the source handover then act on the same output edge. The bench provokes this by writing the select and the gate-2 enable in back-to-back cycles, and by flipping all enables in bursts with irregular gaps. It judges the result by the rising-edge counts in a 60-root-cycle window and by the shortest high pulse seen on each output, compared with the high phase of that output's parent.

// File: rtl/ckt_pkg.sv
package ckt_pkg;

    // Clock source feeding a gated output
    typedef enum logic [2:0] {
        SRC_CORE,
        SRC_X2,
        SRC_PKT,
        SRC_SD,
        SRC_STOR,
        SRC_NONE
    } src_e;

    // Bundle of derived clocks leaving the divider stage
    typedef struct packed {
        logic pkt;
        logic x2;
        logic core;
        logic sd;
    } dclk_t;

    // Gating bits that exist (10, 19 and 20 are holes)
    localparam logic [31:0] USED_DEFAULT = 32'hFFE7_FBFF;

    // Fixed parent for gate idx
    function automatic src_e gate_src(input int idx, input logic [31:0] used);
        if (idx < 0 || idx > 31) return SRC_NONE;
        if (!used[idx]) return SRC_NONE;
        case (idx)
            2:                  return SRC_STOR;
            4:                  return SRC_SD;
            3, 5, 9:            return SRC_PKT;
            13, 14, 17, 25, 26: return SRC_X2;
            default:            return SRC_CORE;
        endcase
    endfunction

endpackage

// File: rtl/ckt_div.sv
module ckt_div
    import ckt_pkg::*;
(
    input  logic  clk_root,
    input  logic  rst,
    output dclk_t dclk
);
    localparam int PKT_DIV = 3;
    localparam int SD_SLOTS = 5;
    localparam int P3W = $clog2(PKT_DIV);
    localparam int P5W = $clog2(SD_SLOTS);
    localparam logic [P3W-1:0] P3_LAST = P3W'(PKT_DIV - 1);
    localparam logic [P5W-1:0] P5_LAST = P5W'(SD_SLOTS - 1);

    logic [P3W-1:0] cnt3;
    logic [P5W-1:0] cnt5;
    logic           p3, n3, p5, n5;
    logic           x2_q, core_q;

    // Rising-edge half: counters, binary dividers, leading pulse of each fraction
    always_ff @(posedge clk_root) begin
        if (rst) begin
            cnt3   <= '0;
            cnt5   <= '0;
            p3     <= 1'b0;
            p5     <= 1'b0;
            x2_q   <= 1'b0;
            core_q <= 1'b0;
        end else begin
            cnt3   <= (cnt3 == P3_LAST) ? '0 : cnt3 + P3W'(1);
            p3     <= (cnt3 == P3_LAST);
            x2_q   <= ~x2_q;
            if (x2_q) core_q <= ~core_q;
            cnt5   <= (cnt5 == P5_LAST) ? '0 : cnt5 + P5W'(1);
            // pulses start in slots 0 and 3 of the five-slot frame
            p5     <= (cnt5 == P5_LAST) || (cnt5 == P5W'(2));
        end
    end

    // Falling-edge half: stretch each pulse by half a root period
    always_ff @(negedge clk_root) begin
        if (rst) begin
            n3 <= 1'b0;
            n5 <= 1'b0;
        end else begin
            n3 <= p3;
            n5 <= (cnt5 == '0) || (cnt5 == P5W'(2));
        end
    end

    assign dclk.pkt  = p3 | n3;
    assign dclk.x2   = x2_q;
    assign dclk.core = core_q;
    assign dclk.sd   = p5 | n5;

    AST_CORE_ALIGN: assert property (@(posedge clk_root) disable iff (rst)
        !$stable(core_q) |-> !$stable(x2_q)) else $error("core edge off x2 edge"); // R3
    AST_PKT_PULSE: assert property (@(posedge clk_root) disable iff (rst)
        p3 |=> !p3) else $error("pkt lead pulse too long"); // R2
    AST_SD_PULSE: assert property (@(posedge clk_root) disable iff (rst)
        p5 |=> !p5) else $error("sd lead pulse too long"); // R4

endmodule

// File: rtl/ckt_stor_mux.sv
module ckt_stor_mux (
    input  logic clk_root,
    input  logic rst_dom,
    input  logic sel,
    input  logic clk_a,
    input  logic clk_b,
    output logic clk_o
);
    logic a1, a2, b1, b2;

    // Source A (sel = 0): request on rise, grant on fall, blocked while B holds
    always_ff @(posedge clk_a) begin
        if (rst_dom) a1 <= 1'b0;
        else         a1 <= ~sel & ~b2;
    end
    always_ff @(negedge clk_a) begin
        if (rst_dom) a2 <= 1'b0;
        else         a2 <= a1;
    end

    // Source B (sel = 1)
    always_ff @(posedge clk_b) begin
        if (rst_dom) b1 <= 1'b0;
        else         b1 <= sel & ~a2;
    end
    always_ff @(negedge clk_b) begin
        if (rst_dom) b2 <= 1'b0;
        else         b2 <= b1;
    end

    assign clk_o = (clk_a & a2) | (clk_b & b2);

    AST_MUX_EXCL: assert property (@(posedge clk_root) disable iff (rst_dom)
        !(a2 && b2)) else $error("both storage sources granted"); // R6

endmodule

// File: rtl/ckt_gate_cell.sv
module ckt_gate_cell (
    input  logic clk_root,
    input  logic rst_dom,
    input  logic clk_par,
    input  logic en,
    output logic clk_o
);
    logic en_q;

    // Enable is taken on the parent's falling edge: only whole high phases pass
    always_ff @(negedge clk_par) begin
        if (rst_dom) en_q <= 1'b0;
        else         en_q <= en;
    end

    assign clk_o = clk_par & en_q;

    AST_GATE_QUIET: assert property (@(posedge clk_root) disable iff (rst_dom)
        !$stable(en_q) |-> !clk_par) else $error("gate enable moved while parent high"); // R10

endmodule

// File: rtl/ckt_regs.sv
module ckt_regs #(
    parameter int                    ADDR_W      = 12,
    parameter int                    DATA_W      = 32,
    parameter int                    NUM_GATES   = 32,
    parameter logic [ADDR_W-1:0]     GATE_OFS    = 12'h220,
    parameter logic [ADDR_W-1:0]     SEL_OFS     = 12'h700,
    parameter logic [NUM_GATES-1:0]  USED        = '1,
    parameter int                    RST_STRETCH = 8
) (
    input  logic                 clk_root,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_GATES-1:0] gate_en,
    output logic                 stor_sel,
    output logic                 rst_dom
);
    localparam int HW = $clog2(RST_STRETCH + 1);

    logic [NUM_GATES-1:0] gate_q;
    logic                 sel_q;
    logic [HW-1:0]        hold_cnt;

    always_ff @(posedge clk_root) begin
        if (rst) begin
            gate_q <= '0;
            sel_q  <= 1'b0;
        end else if (wr) begin
            if (addr == GATE_OFS) gate_q <= wdata[NUM_GATES-1:0] & USED; // R8
            if (addr == SEL_OFS)  sel_q  <= wdata[0];
        end
    end

    // Reset is held for the derived domains long enough for their slowest clock to see it
    always_ff @(posedge clk_root) begin
        if (rst)                 hold_cnt <= HW'(RST_STRETCH);
        else if (hold_cnt != '0) hold_cnt <= hold_cnt - HW'(1);
    end

    assign rst_dom = rst | (hold_cnt != '0);

    always_comb begin
        rdata = '0;
        if (addr == GATE_OFS)     rdata[NUM_GATES-1:0] = gate_q;
        else if (addr == SEL_OFS) rdata[0] = sel_q;
    end

    assign gate_en  = gate_q;
    assign stor_sel = sel_q;

endmodule

// File: rtl/clkdiv_gate_tree.sv
module clkdiv_gate_tree
    import ckt_pkg::*;
#(
    parameter int                   ADDR_W      = 12,
    parameter int                   DATA_W      = 32,
    parameter int                   NUM_GATES   = 32,
    parameter logic [ADDR_W-1:0]    GATE_OFS    = 12'h220,
    parameter logic [ADDR_W-1:0]    SEL_OFS     = 12'h700,
    parameter logic [NUM_GATES-1:0] USED        = USED_DEFAULT[NUM_GATES-1:0],
    parameter int                   RST_STRETCH = 8
) (
    input  logic                 clk_root,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 clk_pkt,
    output logic                 clk_x2,
    output logic                 clk_core,
    output logic                 clk_sd,
    output logic                 clk_stor,
    output logic [NUM_GATES-1:0] gclk
);
    dclk_t                dclk;
    logic [NUM_GATES-1:0] gate_en;
    logic                 stor_sel;
    logic                 rst_dom;
    logic                 stor_clk;

    ckt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_GATES(NUM_GATES),
        .GATE_OFS(GATE_OFS), .SEL_OFS(SEL_OFS), .USED(USED),
        .RST_STRETCH(RST_STRETCH)
    ) u_regs (
        .clk_root(clk_root), .rst(rst), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .gate_en(gate_en),
        .stor_sel(stor_sel), .rst_dom(rst_dom)
    );

    ckt_div u_div (
        .clk_root(clk_root), .rst(rst), .dclk(dclk)
    );

    ckt_stor_mux u_stor (
        .clk_root(clk_root), .rst_dom(rst_dom), .sel(stor_sel),
        .clk_a(dclk.core), .clk_b(dclk.sd), .clk_o(stor_clk)
    );

    assign clk_pkt  = dclk.pkt;
    assign clk_x2   = dclk.x2;
    assign clk_core = dclk.core;
    assign clk_sd   = dclk.sd;
    assign clk_stor = stor_clk;

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        localparam src_e SRC = gate_src(g, 32'(USED));
        if (SRC == SRC_NONE) begin : g_off
            logic unused_en;
            assign unused_en = gate_en[g];
            assign gclk[g]   = 1'b0;
        end else begin : g_on
            logic par;
            always_comb begin
                case (SRC)
                    SRC_X2:   par = dclk.x2;
                    SRC_PKT:  par = dclk.pkt;
                    SRC_SD:   par = dclk.sd;
                    SRC_STOR: par = stor_clk;
                    default:  par = dclk.core;
                endcase
            end
            ckt_gate_cell u_cell (
                .clk_root(clk_root), .rst_dom(rst_dom), .clk_par(par),
                .en(gate_en[g]), .clk_o(gclk[g])
            );
        end
    end

endmodule

// File: tb/test_clkdiv_gate_tree.sv
`timescale 1ns/1ps
module test_clkdiv_gate_tree;
    localparam int NG = 32;
    localparam int NT = NG + 5;          // 32 gates, then pkt, x2, core, sd, stor
    localparam int I_PKT = NG, I_X2 = NG + 1, I_CORE = NG + 2, I_SD = NG + 3, I_STOR = NG + 4;
    localparam logic [11:0] A_GATE = 12'h220, A_SEL = 12'h700;
    localparam logic [31:0] MASK = 32'hFFE7_FBFF;

    logic        clk = 1'b0, rst = 1'b1, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    wire  [31:0] rdata;
    wire         c_pkt, c_x2, c_core, c_sd, c_stor;
    wire [NG-1:0] gclk;

    clkdiv_gate_tree i_clkdiv_gate_tree (
        .clk_root(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .clk_pkt(c_pkt), .clk_x2(c_x2), .clk_core(c_core),
        .clk_sd(c_sd), .clk_stor(c_stor), .gclk(gclk)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0, fails = 0;
    bit done = 1'b0;

    wire [NT-1:0] mon = {c_stor, c_sd, c_core, c_x2, c_pkt, gclk};
    int  cnt   [NT] = '{default: 0};
    int  delta [NT] = '{default: 0};
    real t_rise[NT] = '{default: 0.0};
    real minw  [NT] = '{default: 1.0e9};
    real lastw [NT] = '{default: 0.0};
    logic [NT-1:0] prev = '0;

    always @(mon) begin
        for (int k = 0; k < NT; k++) begin
            if (mon[k] === 1'b1 && prev[k] !== 1'b1) begin
                cnt[k]++;
                t_rise[k] = $realtime;
            end else if (mon[k] !== 1'b1 && prev[k] === 1'b1) begin
                lastw[k] = $realtime - t_rise[k];
                if (lastw[k] < minw[k]) minw[k] = lastw[k];
            end
        end
        prev = mon;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // Rising edges in exactly 60 root periods (a common multiple of all ratios)
    task automatic measure();
        int snap[NT];
        @(posedge clk); #2;
        for (int k = 0; k < NT; k++) snap[k] = cnt[k];
        repeat (60) @(posedge clk);
        #2;
        for (int k = 0; k < NT; k++) delta[k] = cnt[k] - snap[k];
    endtask

    task automatic clear_minw();
        for (int k = 0; k < NT; k++) minw[k] = 1.0e9;
    endtask

    function automatic int exp_cnt(input int g, input bit sel);
        case (g)
            10, 19, 20:         return 0;
            2:                  return sel ? 24 : 15;
            4:                  return 24;
            3, 5, 9:            return 20;
            13, 14, 17, 25, 26: return 30;
            default:            return 15;
        endcase
    endfunction

    // Parent high phase in ns (root period 8 ns)
    function automatic real exp_hi(input int g);
        case (g)
            2, 4, 3, 5, 9:      return 12.0;
            13, 14, 17, 25, 26: return 8.0;
            default:            return 16.0;
        endcase
    endfunction

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rv;
        bit ok;

        // ---- R1: reset state
        repeat (6) @(posedge clk);
        reg_read(A_GATE, rv); chk(rv == 0, "R1", "gate reg in reset", rv, 0);
        reg_read(A_SEL, rv);  chk(rv == 0, "R1", "select in reset", rv, 0);
        @(negedge clk); rst = 1'b0;
        repeat (30) @(posedge clk);
        measure();
        ok = 1'b1;
        for (int g = 0; g < NG; g++) if (delta[g] != 0) ok = 1'b0;
        chk(ok, "R1", "gated outputs idle after reset", ok, 1);
        reg_read(A_GATE, rv); chk(rv == 0, "R1", "gate reg after reset", rv, 0);

        // ---- free-running clocks
        chk(delta[I_PKT] == 20, "R2", "pkt edges/60", delta[I_PKT], 20);
        chk(lastw[I_PKT] > 11.9 && lastw[I_PKT] < 12.1, "R2", "pkt high ps",
            longint'(lastw[I_PKT] * 1000), 12000);
        chk(delta[I_X2] == 30, "R3", "x2 edges/60", delta[I_X2], 30);
        chk(delta[I_CORE] == 15, "R3", "core edges/60", delta[I_CORE], 15);
        chk(delta[I_SD] == 24, "R4", "sd edges/60", delta[I_SD], 24);
        chk(lastw[I_SD] > 11.9 && lastw[I_SD] < 12.1, "R4", "sd high ps",
            longint'(lastw[I_SD] * 1000), 12000);
        chk(delta[I_STOR] == 15, "R5", "stor edges/60 sel0", delta[I_STOR], 15);

        // ---- R7/R8/R9: one gate at a time
        for (int g = 0; g < NG; g++) begin
            logic [31:0] want;
            want = (32'h1 << g) & MASK;
            reg_write(A_GATE, 32'h1 << g);
            reg_read(A_GATE, rv);
            chk(rv == want, (MASK[g] ? "R7" : "R8"), $sformatf("readback gate %0d", g), rv, want);
            repeat (12) @(posedge clk);
            measure();
            chk(delta[g] == exp_cnt(g, 1'b0), (MASK[g] ? "R9" : "R8"),
                $sformatf("edges gate %0d", g), delta[g], exp_cnt(g, 1'b0));
            ok = 1'b1;
            for (int k = 0; k < NG; k++) if (k != g && delta[k] != 0) ok = 1'b0;
            chk(ok, "R7", $sformatf("others idle with gate %0d", g), ok, 1);
        end

        // ---- all on
        reg_write(A_GATE, 32'hFFFF_FFFF);
        reg_read(A_GATE, rv); chk(rv == MASK, "R8", "readback all ones", rv, MASK);
        repeat (12) @(posedge clk);
        measure();
        ok = 1'b1;
        for (int g = 0; g < NG; g++) if (delta[g] != exp_cnt(g, 1'b0)) ok = 1'b0;
        chk(ok, "R7", "all gates running together", ok, 1);
        chk(delta[10] == 0 && delta[19] == 0 && delta[20] == 0, "R8", "holes idle",
            delta[10] + delta[19] + delta[20], 0);

        // ---- R11: foreign offsets
        reg_write(12'h224, 32'h0);
        reg_write(12'h000, 32'h0);
        reg_write(12'h704, 32'hFFFF_FFFF);
        reg_read(A_GATE, rv); chk(rv == MASK, "R11", "gate reg after foreign writes", rv, MASK);
        reg_read(A_SEL, rv);  chk(rv == 0, "R11", "select after foreign writes", rv, 0);
        reg_read(12'h224, rv); chk(rv == 0, "R11", "foreign read", rv, 0);

        // ---- R5/R6: storage switch with gate 2 enable in adjacent cycles
        reg_write(A_GATE, 32'h0);
        repeat (12) @(posedge clk);
        clear_minw();
        reg_write(A_SEL, 32'hFFFF_FFFF);
        reg_write(A_GATE, 32'h4);
        reg_read(A_SEL, rv); chk(rv == 1, "R5", "select readback bit0 only", rv, 1);
        repeat (20) @(posedge clk);
        measure();
        chk(delta[I_STOR] == 24, "R5", "stor edges/60 sel1", delta[I_STOR], 24);
        chk(delta[2] == 24, "R9", "gate 2 follows stor sel1", delta[2], 24);
        reg_write(A_GATE, 32'h0);
        reg_write(A_SEL, 32'h0);
        reg_write(A_GATE, 32'h4);
        repeat (20) @(posedge clk);
        measure();
        chk(delta[I_STOR] == 15, "R5", "stor edges/60 back to sel0", delta[I_STOR], 15);
        chk(delta[2] == 15, "R9", "gate 2 follows stor sel0", delta[2], 15);
        chk(minw[I_STOR] > 11.9, "R6", "shortest stor high ps",
            longint'(minw[I_STOR] * 1000), 12000);
        chk(minw[2] > 11.9, "R6", "shortest gate 2 high ps",
            longint'(minw[2] * 1000), 12000);

        // ---- R10: bursts of enable flips at irregular gaps
        clear_minw();
        for (int i = 0; i < 64; i++) begin
            reg_write(A_GATE, (i % 2) ? 32'hFFFF_FFFF : 32'h0);
            if (i % 16 == 5) reg_write(A_SEL, {31'b0, ~i[5]});
            repeat (i % 7) @(negedge clk);
        end
        reg_write(A_SEL, 32'h0);
        reg_write(A_GATE, 32'h0);
        repeat (12) @(posedge clk);
        for (int g = 0; g < NG; g++) begin
            if (MASK[g])
                chk(minw[g] > exp_hi(g) - 0.1, "R10", $sformatf("shortest high ps gate %0d", g),
                    longint'(minw[g] * 1000), longint'(exp_hi(g) * 1000));
        end
        measure();
        ok = 1'b1;
        for (int g = 0; g < NG; g++) if (delta[g] != 0) ok = 1'b0;
        chk(ok, "R7", "all idle after clearing", ok, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule